// File: doc/BRIEF.md
# Octal Channel Request and Protection Logic

This block decides, cycle by cycle, whether each of eight low-side output stages should conduct. Every channel has a serial command bit supplied by a register file and may also have a parallel term taken from four input pins. The pins pass through a common polarity stage. The first three pins each feed one fixed channel. The fourth pin is a shared input that can be steered to any set of channels through a mask. A per-channel mode bit chooses whether the parallel and serial terms are combined by OR or by AND.

The combined request is then filtered by per-channel protection. An over-temperature flag cuts the channel off at once. Each channel selects whether it restarts on its own when the flag drops, or stays off until its request rises again. An overload flag can either be tolerated, or, once it has lasted a programmable number of clock cycles, trip a latch that also waits for a fresh rising request. A sleep input forces every channel off and clears all protection state. The resulting enables are also returned as a read-back status vector.

The surrounding register file clears the serial command bits on sleep. This is why, after wake-up, only channels with an active parallel term come back on.

Top module: `octal_chan_ctrl`

## Requirements
- R1: With `pol_hi`=1 a parallel pin reads active when it is 1. With `pol_hi`=0 it reads active when it is 0.
- R2: Pins 0 to 2 form the parallel term of channels 0 to 2. Pin 3 adds to the parallel term of every channel whose `map_sel` bit is 1. A channel from 3 to 7 whose `map_sel` bit is 0 has an inactive parallel term.
- R3: With `and_sel` bit 0 the request is the parallel term OR the `ctl_bits` bit. With `and_sel` bit 1 the request is their AND. With no faults, `gate_en` equals the request in the same cycle.
- R4: A set `ovt_flag` bit forces that `gate_en` bit to 0 in the same cycle. With `ovt_hold` bit 0, the channel turns back on as soon as the flag clears while the request stays 1.
- R5: With `ovt_hold` bit 1, an over-temperature event latches the channel off. The latch survives the flag clearing. It is released at the first clock edge that samples the request at 1 after sampling it at 0, and the channel is on in the cycle after that edge.
- R6: With `ovl_hold` bit 1, an on channel whose `ovl_flag` is 1 at OVL_DLY consecutive clock edges is off after the last of those edges. It stays off until a rising request is sampled, as in R5.
- R7: With `ovl_hold` bit 0, `ovl_flag` has no effect on `gate_en`, however long it stays set.
- R8: While `sleep_req` is 1 all `gate_en` bits are 0, whatever the other inputs. Every protection latch is cleared, so a latched channel whose request stayed 1 turns on at wake.
- R9: `sta` equals `gate_en` at all times.
- R10: An active-low `rst_n` clears all protection latches and delay counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Low-power request: all channels off, protection state cleared |
| pol_hi | input | 1 | Parallel pin polarity, 1 = active high |
| par_in | input | NUM_PAR | Parallel control pins |
| map_sel | input | NUM_CH | Channels driven by the shared last pin |
| and_sel | input | NUM_CH | Per-channel combine mode, 1 = AND, 0 = OR |
| ovl_hold | input | NUM_CH | Per-channel overload latching enable |
| ovt_hold | input | NUM_CH | Per-channel over-temperature latching enable |
| ctl_bits | input | NUM_CH | Serial on/off command bits |
| ovl_flag | input | NUM_CH | Per-channel overload (current-limit active) flag |
| ovt_flag | input | NUM_CH | Per-channel over-temperature flag |
| gate_en | output | NUM_CH | Output stage enables |
| sta | output | NUM_CH | Read-back of the output enables |

## Verification
The bench keeps the default eight channels and four pins, so every mask and combine pattern covers the real channel layout. It overrides OVL_DLY to 5. With that value, the boundary between four and five edges of overload can be checked in a handful of cycles, and so can the tolerated case of twenty edges. Fault, sleep and reset sequences all act on one channel, so any disturbance to the others shows up in the full enable vector.

// File: rtl/oc_pkg.sv
package oc_pkg;

  // Active level of a pin after the polarity stage.
  function automatic logic pin_active(input logic pol_hi, input logic pin);
    return pol_hi ? pin : ~pin;
  endfunction

  // Combination of parallel and serial terms for one channel.
  function automatic logic chan_request(input logic use_and, input logic par,
                                        input logic ser);
    return use_and ? (par & ser) : (par | ser);
  endfunction

endpackage

// File: rtl/oc_input_map.sv
module oc_input_map #(
  parameter int NUM_CH  = 8,
  parameter int NUM_PAR = 4
) (
  input  logic               pol_hi,
  input  logic [NUM_PAR-1:0] par_in,
  input  logic [NUM_CH-1:0]  map_sel,
  output logic [NUM_CH-1:0]  par_term
);
  import oc_pkg::*;

  localparam int NUM_FIXED = NUM_PAR - 1;
  localparam int SHARED    = NUM_PAR - 1;

  logic [NUM_PAR-1:0] pin_act;

  for (genvar p = 0; p < NUM_PAR; p++) begin : g_pol
    assign pin_act[p] = pin_active(pol_hi, par_in[p]);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    if (c < NUM_FIXED) begin : g_fixed
      assign par_term[c] = pin_act[c] | (map_sel[c] & pin_act[SHARED]);
    end else begin : g_shared
      assign par_term[c] = map_sel[c] & pin_act[SHARED];
    end
  end

endmodule

// File: rtl/oc_chan_guard.sv
module oc_chan_guard #(
  parameter int OVL_DLY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic req,
  input  logic ovt_flag,
  input  logic ovl_flag,
  input  logic ovt_hold,
  input  logic ovl_hold,
  output logic gate,
  output logic rise,
  output logic ovt_lat,
  output logic ovl_lat
);
  localparam int CW = (OVL_DLY < 2) ? 1 : $clog2(OVL_DLY);
  localparam logic [CW-1:0] LAST = CW'(OVL_DLY - 1);

  logic          req_q;
  logic [CW-1:0] dly_cnt;
  logic          ovl_run;
  logic          ovl_trip;
  logic          ovt_set;

  assign rise     = req & ~req_q;
  assign gate     = ~sleep_req & req & ~ovt_flag & ~ovt_lat & ~ovl_lat;
  assign ovt_set  = ovt_hold & ovt_flag;
  assign ovl_run  = ovl_hold & ovl_flag & gate;
  assign ovl_trip = ovl_run & (dly_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      ovt_lat <= 1'b0;
      ovl_lat <= 1'b0;
      dly_cnt <= '0;
    end else begin
      req_q <= req;
      if (sleep_req) begin
        ovt_lat <= 1'b0;
        ovl_lat <= 1'b0;
        dly_cnt <= '0;
      end else begin
        if (ovt_set)   ovt_lat <= 1'b1;
        else if (rise) ovt_lat <= 1'b0;

        if (ovl_trip)  ovl_lat <= 1'b1;
        else if (rise) ovl_lat <= 1'b0;

        if (ovl_run && !ovl_trip) dly_cnt <= dly_cnt + 1'b1;
        else                      dly_cnt <= '0;
      end
    end
  end

endmodule

// File: rtl/octal_chan_ctrl.sv
module octal_chan_ctrl #(
  parameter int NUM_CH  = 8,
  parameter int NUM_PAR = 4,
  parameter int OVL_DLY = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleep_req,
  input  logic               pol_hi,
  input  logic [NUM_PAR-1:0] par_in,
  input  logic [NUM_CH-1:0]  map_sel,
  input  logic [NUM_CH-1:0]  and_sel,
  input  logic [NUM_CH-1:0]  ovl_hold,
  input  logic [NUM_CH-1:0]  ovt_hold,
  input  logic [NUM_CH-1:0]  ctl_bits,
  input  logic [NUM_CH-1:0]  ovl_flag,
  input  logic [NUM_CH-1:0]  ovt_flag,
  output logic [NUM_CH-1:0]  gate_en,
  output logic [NUM_CH-1:0]  sta
);
  import oc_pkg::*;

  logic [NUM_CH-1:0] par_term;
  logic [NUM_CH-1:0] req_vec;
  logic [NUM_CH-1:0] rise_vec;
  logic [NUM_CH-1:0] ovt_lat_vec;
  logic [NUM_CH-1:0] ovl_lat_vec;

  oc_input_map #(.NUM_CH(NUM_CH), .NUM_PAR(NUM_PAR)) u_map (
    .pol_hi  (pol_hi),
    .par_in  (par_in),
    .map_sel (map_sel),
    .par_term(par_term)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign req_vec[c] = chan_request(and_sel[c], par_term[c], ctl_bits[c]);

    oc_chan_guard #(.OVL_DLY(OVL_DLY)) u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .sleep_req(sleep_req),
      .req      (req_vec[c]),
      .ovt_flag (ovt_flag[c]),
      .ovl_flag (ovl_flag[c]),
      .ovt_hold (ovt_hold[c]),
      .ovl_hold (ovl_hold[c]),
      .gate     (gate_en[c]),
      .rise     (rise_vec[c]),
      .ovt_lat  (ovt_lat_vec[c]),
      .ovl_lat  (ovl_lat_vec[c])
    );
  end

  assign sta = gate_en;

endmodule

// File: rtl/oc_chk.sv
module oc_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep_req,
  input logic [NUM_CH-1:0] ovt_flag,
  input logic [NUM_CH-1:0] ovl_hold,
  input logic [NUM_CH-1:0] gate_en,
  input logic [NUM_CH-1:0] sta,
  input logic [NUM_CH-1:0] req_vec,
  input logic [NUM_CH-1:0] rise_vec,
  input logic [NUM_CH-1:0] ovt_lat_vec,
  input logic [NUM_CH-1:0] ovl_lat_vec
);

  // R3
  gate_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en & ~req_vec) == '0);

  // R4
  ovt_cuts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en & ovt_flag) == '0);

  // R8
  sleep_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> (gate_en == '0));

  // R9
  sta_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sta == gate_en);

  // R6
  ovl_latch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_req |=> (($past(ovl_lat_vec & ~rise_vec) & ~ovl_lat_vec) == '0));

  // R5
  ovt_latch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_req |=> (($past(ovt_lat_vec & ~rise_vec) & ~ovt_lat_vec) == '0));

  // R7
  ovl_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovl_lat_vec[0]) |-> $past(ovl_hold[0]));

endmodule

bind octal_chan_ctrl oc_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sleep_req  (sleep_req),
  .ovt_flag   (ovt_flag),
  .ovl_hold   (ovl_hold),
  .gate_en    (gate_en),
  .sta        (sta),
  .req_vec    (req_vec),
  .rise_vec   (rise_vec),
  .ovt_lat_vec(ovt_lat_vec),
  .ovl_lat_vec(ovl_lat_vec)
);

// File: tb/octal_chan_ctrl_tb.sv
`timescale 1ns/1ps
module octal_chan_ctrl_tb;

  localparam int NCH = 8;
  localparam int NPAR = 4;
  localparam int DLY = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0;
  logic pol_hi = 1'b1;
  logic [NPAR-1:0] par_in = '0;
  logic [NCH-1:0] map_sel = 8'h08;
  logic [NCH-1:0] and_sel = '0;
  logic [NCH-1:0] ovl_hold = '0;
  logic [NCH-1:0] ovt_hold = '0;
  logic [NCH-1:0] ctl_bits = '0;
  logic [NCH-1:0] ovl_flag = '0;
  logic [NCH-1:0] ovt_flag = '0;
  logic [NCH-1:0] gate_en;
  logic [NCH-1:0] sta;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  octal_chan_ctrl #(.NUM_CH(NCH), .NUM_PAR(NPAR), .OVL_DLY(DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .pol_hi(pol_hi),
    .par_in(par_in), .map_sel(map_sel), .and_sel(and_sel),
    .ovl_hold(ovl_hold), .ovt_hold(ovt_hold), .ctl_bits(ctl_bits),
    .ovl_flag(ovl_flag), .ovt_flag(ovt_flag), .gate_en(gate_en), .sta(sta)
  );

  typedef struct packed {
    logic       pol;
    logic [3:0] pin;
    logic [7:0] map;
    logic [7:0] band;
    logic [7:0] ctl;
    logic [7:0] exp;
  } vec_t;

  // Fault-free combinations: polarity, mapping, OR/AND mix.
  localparam vec_t VECS [8] = '{
    '{1'b1, 4'b0000, 8'h08, 8'h00, 8'h00, 8'h00},
    '{1'b1, 4'b0001, 8'h08, 8'h00, 8'h00, 8'h01},
    '{1'b1, 4'b1000, 8'h08, 8'h00, 8'h00, 8'h08},
    '{1'b1, 4'b1000, 8'hF1, 8'h00, 8'h00, 8'hF1},
    '{1'b0, 4'b1111, 8'h08, 8'h00, 8'hA5, 8'hA5},
    '{1'b0, 4'b0000, 8'hFF, 8'hFF, 8'h0F, 8'h0F},
    '{1'b0, 4'b0110, 8'h30, 8'h0F, 8'hC3, 8'hF1},
    '{1'b1, 4'b0110, 8'h00, 8'h02, 8'h01, 8'h05}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R10 reset gate state", gate_en, 8'h00);
    chk("R9 reset status", sta, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      pol_hi = VECS[i].pol;
      par_in = VECS[i].pin;
      map_sel = VECS[i].map;
      and_sel = VECS[i].band;
      ctl_bits = VECS[i].ctl;
      #1;
      chk($sformatf("R1/R2/R3 vector %0d", i), gate_en, VECS[i].exp);
      chk($sformatf("R9 vector %0d", i), sta, VECS[i].exp);
    end

    // R4: immediate cut and auto restart on channel 2
    @(negedge clk);
    pol_hi = 1'b1; par_in = '0; map_sel = 8'h08; and_sel = '0; ctl_bits = 8'h04;
    #1 chk("R3 serial only", gate_en, 8'h04);
    @(negedge clk);
    ovt_flag = 8'h04;
    #1 chk("R4 immediate cut", gate_en, 8'h00);
    @(negedge clk);
    ovt_flag = 8'h00;
    #1 chk("R4 auto restart", gate_en, 8'h04);

    // R5: latched over-temperature
    @(negedge clk);
    ovt_hold = 8'h04; ovt_flag = 8'h04;
    @(negedge clk);
    ovt_flag = 8'h00;
    #1 chk("R5 held after flag clears", gate_en, 8'h00);
    repeat (3) @(negedge clk);
    #1 chk("R5 still held", gate_en, 8'h00);
    ctl_bits = 8'h00;
    @(negedge clk);
    ctl_bits = 8'h04;
    #1 chk("R5 rise not yet sampled", gate_en, 8'h00);
    @(posedge clk);
    #1 chk("R5 released by rise", gate_en, 8'h04);

    // R6: latched overload after DLY edges
    @(negedge clk);
    ovt_hold = 8'h00; ovl_hold = 8'h04; ovl_flag = 8'h04;
    repeat (DLY - 1) @(posedge clk);
    #1 chk("R6 on before delay", gate_en, 8'h04);
    @(posedge clk);
    #1 chk("R6 off at delay", gate_en, 8'h00);
    @(negedge clk);
    ovl_flag = 8'h00;
    @(posedge clk);
    #1 chk("R6 held without rise", gate_en, 8'h00);
    @(negedge clk);
    ctl_bits = 8'h00;
    @(negedge clk);
    ctl_bits = 8'h04;
    @(posedge clk);
    #1 chk("R6 released by rise", gate_en, 8'h04);

    // R7: overload tolerated
    @(negedge clk);
    ovl_hold = 8'h00; ovl_flag = 8'h04;
    repeat (20) @(posedge clk);
    #1 chk("R7 overload ignored", gate_en, 8'h04);
    @(negedge clk);
    ovl_flag = 8'h00;

    // R8: sleep forces off and clears latches
    @(negedge clk);
    ovt_hold = 8'h04; ovt_flag = 8'h04;
    @(negedge clk);
    ovt_flag = 8'h00;
    #1 chk("R8 pre-sleep latched", gate_en, 8'h00);
    sleep_req = 1'b1; ctl_bits = 8'hFF; par_in = 4'b0001;
    #1 chk("R8 sleep all off", gate_en, 8'h00);
    repeat (2) @(negedge clk);
    #1 chk("R9 sleep status", sta, 8'h00);
    sleep_req = 1'b0; ctl_bits = 8'h04;
    #1 chk("R8 wake clears latch", gate_en, 8'h05);
    @(negedge clk);
    par_in = 4'b0000; ovt_hold = 8'h00;

    // R10: reset clears an overload latch
    @(negedge clk);
    ovl_hold = 8'h04; ovl_flag = 8'h04;
    repeat (DLY) @(posedge clk);
    #1 chk("R6 tripped before reset", gate_en, 8'h00);
    @(negedge clk);
    ovl_flag = 8'h00; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R10 latch cleared by reset", gate_en, 8'h04);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule